// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block schedules conversions for an analog-to-digital converter that sits outside it. A host writes one 16-bit control word that holds a per-source select mask for eleven sources and a flag that asks for repeated scans. The sequencer works through the selected sources one at a time. For each source it raises a request to the converter and waits for the converter's done pulse. It then stores the result, tagged with the source index, in a result FIFO that the host drains.

Source 0 is the on-die temperature sensor. Sources 1 to 5 are the first amplifier channel's remote temperature, sense voltage, DAC code, gate voltage and spare input. Sources 6 to 10 are the same five quantities for the second channel. The two gate-voltage sources are converted only while their power-down inputs are low. Repeated scanning depends on the clock-mode input. Results are stored only while the monitor-enable input is high.

Top module: `adcScanSeq`

## Requirements
- R1: After reset the FIFO is empty (`fifoEmpty`=1, `fifoFull`=0), `fifoOvf` is 0, `convReq` is 0, and the stored control word is all zeros, so no scan runs.
- R2: A scan visits each selected source once, lowest bit index first. Control word bit k (k=0..10) selects source k, and `convSrc` carries k during its request. A scan with no selected sources issues no request.
- R3: Source 4 is skipped when `gatePd1` is 1 at the start of the scan, and source 9 is skipped when `gatePd2` is 1 at the start of the scan.
- R4: Each stored entry is {source index[15:12], result[11:0]}. Entries are read first in, first out. `fifoRdData` shows the oldest entry, and a cycle with `fifoRdEn` high while the FIFO is not empty removes that entry.
- R5: A result that completes while `monEn` is 0 is discarded and leaves the FIFO unchanged.
- R6: When control bit 11 is 1 and `clkMode` is 00 or 01, the scan restarts after its last source, for as long as the mode holds. When `clkMode` is 10 or 11, a control word with bit 11 set runs one scan only.
- R7: Control bits 15..12 have no effect.
- R8: The FIFO holds FIFO_DEPTH entries, and `fifoFull` is high when it holds that many. A result that arrives while the FIFO is full is dropped and sets `fifoOvf`. `fifoOvf` stays set until a cycle with `ovfClr` high.
- R9: Writing a word with bit 11 clear during a repeating scan lets the conversion in progress finish, then stops. No further request follows.
- R10: A control write during a scan does not change that scan. The next scan uses the new word.
- R11: `convReq` stays high with a stable `convSrc` until the cycle in which `convDone` is sampled high, and is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 16 | Control word: select mask [10:0], repeat flag [11] |
| clkMode | input | 2 | Converter clock mode; 00/01 allow repeated scans |
| gatePd1 | input | 1 | Power-down of gate sense, channel 1 (source 4) |
| gatePd2 | input | 1 | Power-down of gate sense, channel 2 (source 9) |
| monEn | input | 1 | Store results when high |
| convReq | output | 1 | Conversion request to the converter |
| convSrc | output | 4 | Source index for the current request |
| convDone | input | 1 | Converter result valid pulse |
| convData | input | RES_W | Converter result |
| fifoRdEn | input | 1 | Pop the oldest FIFO entry |
| fifoRdData | output | 4+RES_W | Oldest FIFO entry {tag, result} |
| fifoEmpty | output | 1 | FIFO holds no entry |
| fifoFull | output | 1 | FIFO holds FIFO_DEPTH entries |
| fifoOvf | output | 1 | Sticky overflow flag |
| ovfClr | input | 1 | Clear the overflow flag |

## Verification
The bench builds the block with FIFO_DEPTH=8 and RES_W=12. The shallow FIFO means one scan of all eleven sources overfills it, so the drop and sticky-flag behaviour can be tested without leaving the FIFO undrained across repeated scans. With the default result width, every tag and result pattern the converter stub returns can be compared bit for bit. Repeated scanning is run once in an allowed clock mode and once in a blocked one.

// File: rtl/scanPkg.sv
package scanPkg;
  localparam int SRC_COUNT  = 11;
  localparam int SRC_W      = 4;
  localparam int CFG_W      = 16;
  localparam int REPEAT_BIT = 11;
  localparam int GATE_A_BIT = 4;
  localparam int GATE_B_BIT = 9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PICK = 2'd1,
    ST_BUSY = 2'd2
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             push;
    logic [SRC_W-1:0] tag;
  } scanStrobe_t;
endpackage

// File: rtl/lowestPick.sv
module lowestPick #(
  parameter int N = 11,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/scanCtrl.sv
module scanCtrl
  import scanPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic [1:0]        clkMode,
  input  logic              gatePd1,
  input  logic              gatePd2,
  input  logic              monEn,
  input  logic              convDone,
  output logic              convReq,
  output logic [SRC_W-1:0]  convSrc,
  output scanStrobe_t       strobe
);
  localparam logic [SRC_COUNT-1:0] ONE = SRC_COUNT'(1);

  scanState_t             state;
  logic [SRC_COUNT-1:0]   cfgMask;
  logic                   cfgRepeat;
  logic [SRC_COUNT-1:0]   remMask;
  logic [SRC_W-1:0]       curSrc;
  logic                   repLatched;
  logic                   startPend;
  logic                   stopReq;

  logic [SRC_COUNT-1:0]   qualMask;
  logic                   repeatOk;
  logic [SRC_W-1:0]       lowIdx;
  logic                   lowAny;

  // gate sources are masked while powered down
  always_comb begin
    qualMask = cfgMask;
    if (gatePd1) qualMask[GATE_A_BIT] = 1'b0;
    if (gatePd2) qualMask[GATE_B_BIT] = 1'b0;
  end

  assign repeatOk = cfgRepeat && (clkMode inside {2'b00, 2'b01});

  lowestPick #(.N(SRC_COUNT)) uPick (
    .vec(remMask),
    .idx(lowIdx),
    .any(lowAny)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cfgMask    <= '0;
      cfgRepeat  <= 1'b0;
      remMask    <= '0;
      curSrc     <= '0;
      repLatched <= 1'b0;
      startPend  <= 1'b0;
      stopReq    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startPend) begin
            startPend <= 1'b0;
            if (qualMask != '0) begin
              remMask    <= qualMask;
              repLatched <= repeatOk;
              state      <= ST_PICK;
            end
          end
        end
        ST_PICK: begin
          if (stopReq) begin
            stopReq <= 1'b0;
            state   <= ST_IDLE;
          end else if (!lowAny) begin
            if (repLatched && qualMask != '0) begin
              remMask    <= qualMask;
              repLatched <= repeatOk;
              startPend  <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            curSrc  <= lowIdx;
            remMask <= remMask & ~(ONE << lowIdx);
            state   <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (convDone) state <= ST_PICK;
        end
        default: state <= ST_IDLE;
      endcase

      // control writes: applied at the next scan start
      if (cfgWrEn) begin
        cfgMask   <= cfgWrData[SRC_COUNT-1:0];
        cfgRepeat <= cfgWrData[REPEAT_BIT];
        if (state != ST_IDLE && repLatched && !cfgWrData[REPEAT_BIT])
          stopReq <= 1'b1;
        else
          startPend <= 1'b1;
      end
    end
  end

  assign convReq     = (state == ST_BUSY);
  assign convSrc     = curSrc;
  assign strobe.push = (state == ST_BUSY) && convDone && monEn;
  assign strobe.tag  = curSrc;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    convReq && !convDone |=> convReq && $stable(convSrc)); // R11
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    convReq && convDone |=> !convReq); // R11
  AST_SRC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> convSrc < SRC_W'(SRC_COUNT)); // R2
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    stopReq && !convReq |=> !convReq); // R9
endmodule

// File: rtl/scanData.sv
module scanData
  import scanPkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int RES_W      = 12,
  localparam int ENT_W = SRC_W + RES_W,
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  scanStrobe_t      strobe,
  input  logic [RES_W-1:0] convData,
  input  logic             popEn,
  input  logic             ovfClr,
  output logic [ENT_W-1:0] rdData,
  output logic             empty,
  output logic             full,
  output logic             ovf
);
  logic [ENT_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(FIFO_DEPTH));
  assign doPush = strobe.push && !full;
  assign doPop  = popEn && !empty;
  assign rdData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {strobe.tag, convData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
      if (strobe.push && full) ovf <= 1'b1;
      else if (ovfClr)         ovf <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push && full |=> ovf); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovf && !ovfClr |=> ovf); // R8
  AST_EMPTY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !(empty && full)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.push && !popEn |=> $stable(count)); // R5
endmodule

// File: rtl/adcScanSeq.sv
module adcScanSeq
  import scanPkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int RES_W      = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWrEn,
  input  logic [CFG_W-1:0]         cfgWrData,
  input  logic [1:0]               clkMode,
  input  logic                     gatePd1,
  input  logic                     gatePd2,
  input  logic                     monEn,
  output logic                     convReq,
  output logic [SRC_W-1:0]         convSrc,
  input  logic                     convDone,
  input  logic [RES_W-1:0]         convData,
  input  logic                     fifoRdEn,
  output logic [SRC_W+RES_W-1:0]   fifoRdData,
  output logic                     fifoEmpty,
  output logic                     fifoFull,
  output logic                     fifoOvf,
  input  logic                     ovfClr
);
  scanStrobe_t strobe;

  scanCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .clkMode(clkMode), .gatePd1(gatePd1), .gatePd2(gatePd2),
    .monEn(monEn), .convDone(convDone),
    .convReq(convReq), .convSrc(convSrc), .strobe(strobe)
  );

  scanData #(.FIFO_DEPTH(FIFO_DEPTH), .RES_W(RES_W)) uData (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .convData(convData),
    .popEn(fifoRdEn), .ovfClr(ovfClr),
    .rdData(fifoRdData), .empty(fifoEmpty), .full(fifoFull), .ovf(fifoOvf)
  );
endmodule

// File: tb/tb_adcScanSeq.sv
module tb_adcScanSeq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int RES_W = 12;
  localparam int LAT = 3;
  localparam int NVEC = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic [1:0] clkMode = 2'b00;
  logic gatePd1 = 1'b0, gatePd2 = 1'b0, monEn = 1'b1;
  logic convReq;
  logic [3:0] convSrc;
  logic convDone = 1'b0;
  logic [RES_W-1:0] convData = '0;
  logic fifoRdEn = 1'b0, ovfClr = 1'b0;
  logic [15:0] fifoRdData;
  logic fifoEmpty, fifoFull, fifoOvf;

  int total = 0, bad = 0;
  int logSrc [64];
  int logN = 0;
  int lat = 0;
  logic [3:0] holdSrc = '0;
  logic srcBad = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcScanSeq #(.FIFO_DEPTH(DEPTH), .RES_W(RES_W)) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .clkMode(clkMode), .gatePd1(gatePd1), .gatePd2(gatePd2), .monEn(monEn),
    .convReq(convReq), .convSrc(convSrc), .convDone(convDone), .convData(convData),
    .fifoRdEn(fifoRdEn), .fifoRdData(fifoRdData), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .fifoOvf(fifoOvf), .ovfClr(ovfClr)
  );

  function automatic logic [RES_W-1:0] dataOf(input int s);
    return RES_W'(12'h700 + s * 17);
  endfunction

  // behavioural converter stub
  always @(negedge clk) begin
    if (convDone) convDone = 1'b0;
    else if (convReq) begin
      if (lat == 0) holdSrc = convSrc;
      else if (convSrc != holdSrc) srcBad = 1'b1;
      if (lat == LAT) begin
        convDone = 1'b1;
        convData = dataOf(int'(convSrc));
        if (logN < 64) logSrc[logN] = int'(convSrc);
        logN++;
        lat = 0;
      end else lat++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [15:0] w);
    cfgWrData = w;
    cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic drain(input bit doCheck, output int n);
    n = 0;
    while (!fifoEmpty && n < 32) begin
      if (doCheck && n < 64) begin
        check(int'(fifoRdData[15:12]) == logSrc[n], "R4 tag", int'(fifoRdData[15:12]), logSrc[n]);
        check(fifoRdData[11:0] == dataOf(logSrc[n]), "R4 data",
              int'(fifoRdData[11:0]), int'(dataOf(logSrc[n])));
      end
      fifoRdEn = 1'b1;
      @(negedge clk);
      fifoRdEn = 1'b0;
      n++;
    end
  endtask

  // {word[15:0], pd1, pd2, mon, expected visited mask[10:0]}
  localparam logic [29:0] VECS [NVEC] = '{
    {16'h0005, 1'b0, 1'b0, 1'b1, 11'h005},
    {16'h0210, 1'b0, 1'b0, 1'b1, 11'h210},
    {16'h0210, 1'b1, 1'b0, 1'b1, 11'h200},
    {16'h0210, 1'b1, 1'b1, 1'b1, 11'h000},
    {16'h0423, 1'b0, 1'b0, 1'b0, 11'h423},
    {16'hF401, 1'b0, 1'b0, 1'b1, 11'h401},
    {16'h0000, 1'b0, 1'b0, 1'b1, 11'h000},
    {16'h00C8, 1'b0, 1'b0, 1'b1, 11'h0C8}
  };

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, c;
    logic [10:0] got;
    bit asc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(fifoEmpty == 1'b1, "R1 empty", int'(fifoEmpty), 1);
    check(fifoFull == 1'b0, "R1 full", int'(fifoFull), 0);
    check(fifoOvf == 1'b0, "R1 ovf", int'(fifoOvf), 0);
    repeat (20) @(negedge clk);
    check(convReq == 1'b0 && logN == 0, "R1 no scan", logN, 0);

    for (int v = 0; v < NVEC; v++) begin
      gatePd1 = VECS[v][13];
      gatePd2 = VECS[v][12];
      monEn   = VECS[v][11];
      logN = 0; srcBad = 1'b0;
      writeCfg(VECS[v][29:14]);
      repeat (150) @(negedge clk);
      got = '0; asc = 1'b1;
      for (int i = 0; i < logN && i < 64; i++) begin
        got[logSrc[i]] = 1'b1;
        if (i > 0 && logSrc[i] <= logSrc[i-1]) asc = 1'b0;
      end
      check(got == VECS[v][10:0], "R2 R3 visited", int'(got), int'(VECS[v][10:0]));
      check(asc, "R2 order", int'(asc), 1);
      check(logN == $countones(VECS[v][10:0]), "R6 R7 single scan", logN,
            $countones(VECS[v][10:0]));
      check(!srcBad, "R11 src stable", int'(srcBad), 0);
      drain(1'b1, n);
      c = VECS[v][11] ? $countones(VECS[v][10:0]) : 0;
      check(n == c, "R4 R5 stored", n, c);
      check(fifoOvf == 1'b0, "R8 no ovf", int'(fifoOvf), 0);
    end
    gatePd1 = 1'b0; gatePd2 = 1'b0; monEn = 1'b1;

    // R8 overflow with all sources
    logN = 0;
    writeCfg(16'h07FF);
    repeat (200) @(negedge clk);
    check(logN == 11, "R2 all sources", logN, 11);
    check(fifoFull == 1'b1, "R8 full", int'(fifoFull), 1);
    check(fifoOvf == 1'b1, "R8 ovf set", int'(fifoOvf), 1);
    drain(1'b1, n);
    check(n == DEPTH, "R8 kept first", n, DEPTH);
    check(fifoOvf == 1'b1, "R8 sticky", int'(fifoOvf), 1);
    ovfClr = 1'b1; @(negedge clk); ovfClr = 1'b0;
    check(fifoOvf == 1'b0, "R8 clear", int'(fifoOvf), 0);

    // R6 repeat in allowed mode, then R9 stop
    monEn = 1'b0; clkMode = 2'b01; logN = 0;
    writeCfg(16'h0803);
    repeat (100) @(negedge clk);
    check(logN >= 6, "R6 repeat", logN, 6);
    writeCfg(16'h0003);
    c = logN;
    repeat (60) @(negedge clk);
    check(logN - c <= 1, "R9 stop count", logN - c, 1);
    check(convReq == 1'b0, "R9 quiet", int'(convReq), 0);
    check(fifoEmpty == 1'b1, "R5 discarded", int'(fifoEmpty), 1);

    // R6 blocked mode runs once
    clkMode = 2'b10; logN = 0;
    writeCfg(16'h0803);
    repeat (100) @(negedge clk);
    check(logN == 2, "R6 blocked mode", logN, 2);

    // R10 write during scan
    clkMode = 2'b00; monEn = 1'b1; logN = 0;
    writeCfg(16'h0007);
    repeat (6) @(negedge clk);
    writeCfg(16'h0030);
    repeat (150) @(negedge clk);
    check(logN == 5, "R10 count", logN, 5);
    check(logSrc[2] == 2 && logSrc[3] == 4 && logSrc[4] == 5, "R10 order", logSrc[3], 4);
    drain(1'b1, n);
    check(n == 5, "R10 R4 stored", n, 5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule